// File: doc/BRIEF.md
# Converter Result Readout Controller

This block sits between a delta-sigma conversion engine and a serial peripheral (SPI) slave port. Each finished conversion arrives as a 24-bit word with a one-cycle strobe. The word goes into a holding buffer, and the active-low ready line `drdy_n` goes low. A host frames transfers with `cs_n`, toggles `sclk` and reads `dout`. Outgoing bits change on the falling `sclk` edge and are MSB first. Command bits on `din` are captured on the rising edge.

The block has two modes. In continuous mode, which is the reset mode, every finished result goes straight into the output shift register. The host can then clock it out with no command at all. The result also overwrites any transfer in progress. In stopped mode, the shift register changes only when the host asks for data or registers. Conversions keep filling the holding buffer in the background.

The block decodes these command bytes:

| Byte | Action |
|------|--------|
| `0x12` | Read data |
| `0x14` | Start continuous mode |
| `0x16` | Stop continuous mode |
| `0x2a` | Read registers from start address `a`, then take a count byte |

The result port has no back-pressure. A strobe on `conv_valid` is always taken in the cycle it appears, so the engine never waits. All inputs are synchronous to `clk`.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset the block is in continuous mode, `drdy_n` is high and the output shift register holds zero. `dout` is low while `cs_n` is high, and otherwise shows the shift register MSB.
- R2: A `conv_valid` strobe drives `drdy_n` low on the next cycle in either mode. In continuous mode the strobe also copies `conv_data` into the output shift register.
- R3: In continuous mode, 24 `sclk` periods that carry no recognised command byte (for example `0x00`) return the latest result MSB first. Each new bit appears after a falling `sclk` edge.
- R4: When read-data (`0x12`) is clocked in, the 8 bits that leave `dout` meanwhile are the top byte of the shift register. At the falling edge that ends the command byte, the shift register is loaded from the holding buffer. The next 24 bits are that result.
- R5: In continuous mode, a result that arrives during any transfer reloads the shift register with the new result. It also returns the byte decoder to its command state with an empty bit count, so the next 24 bits are the new result.
- R6: Stop-continuous (`0x16`) leaves exactly one more automatic load, at the next `conv_valid`. After that load the block is in stopped mode and later results do not change `dout`.
- R7: In stopped mode, `conv_valid` still lowers `drdy_n` and updates the holding buffer. A read-data command returns the latest finished result. A result that arrives during that read does not disturb the bits being shifted out.
- R8: Start-continuous (`0x14`) restores continuous mode and cancels a pending stop.
- R9: Register read `0x2a` followed by count byte `n` shifts out `n+1` bytes of `reg_bank`. Register `i` sits at bits `8*i+7:8*i`. Reading starts at address `a mod NREG`, rises by one per byte and wraps past `NREG-1`.
- R10: `drdy_n` returns high on the 24th shift after a data load (automatic or read-data), or on a `conv_soon` pulse. Otherwise it stays high until the next `conv_valid`.
- R11: Raising `cs_n` clears the bit count and the command decoder. It keeps the mode, the holding buffer and the shift register.
- R12: Bytes on `din` during the data bytes that follow read-data, or during the register bytes that follow a register read, are not decoded as commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is complete |
| conv_data | input | DW (24) | Conversion result, valid with `conv_valid` |
| conv_soon | input | 1 | Pulse one `sclk` period before the next result is due |
| reg_bank | input | NREG*8 (32) | Register file contents, register `i` in byte `i` |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial command input |
| dout | output | 1 | Serial data output, MSB first |
| drdy_n | output | 1 | Active-low data-ready |

## Verification
The assertions assume the following about the inputs:
- `sclk`, `cs_n` and `din` change only between clock edges and are slow compared with `clk`.
- `cs_n` moves only while `sclk` is low.
- `conv_valid` and `conv_soon` never pulse in the same cycle.
- A result strobe never lands on the same cycle as an `sclk` edge.

The stimulus keeps within these limits in four ways:
- It holds each `sclk` phase for several clocks.
- It changes chip select only with `sclk` low.
- It issues conversion strobes only between whole bytes, including strobes that arrive mid-transfer to test overwrite and stopped-mode immunity.
- It pulses `conv_soon` only after a result has settled.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_CNT, PH_REG, PH_DATA} phase_e;
  localparam logic [7:0] OP_RDATA = 8'h12;
  localparam logic [7:0] OP_START = 8'h14;
  localparam logic [7:0] OP_STOP  = 8'h16;
  localparam logic [3:0] OP_RREG  = 4'h2;
endpackage

// File: rtl/adc_rd_edge.sv
module adc_rd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;
endmodule

// File: rtl/adc_rd_mode.sv
module adc_rd_mode (
  input  logic clk,
  input  logic rst,
  input  logic conv_valid,
  input  logic start_cmd,
  input  logic stop_cmd,
  output logic cont,
  output logic stop_pend,
  output logic auto_load
);
  assign auto_load = conv_valid & cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      cont      <= 1'b1;
      stop_pend <= 1'b0;
    end else if (start_cmd) begin
      cont      <= 1'b1;
      stop_pend <= 1'b0;
    end else if (auto_load && stop_pend) begin
      cont      <= 1'b0;
      stop_pend <= 1'b0;
    end else if (stop_cmd && cont) begin
      stop_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_drdy.sv
module adc_rd_drdy #(
  parameter int DW = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_valid,
  input  logic conv_soon,
  input  logic data_load,
  input  logic reg_load,
  input  logic shift,
  output logic drdy_n
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] cnt;
  logic          track;
  logic          last_bit;

  assign last_bit = shift && track && (cnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      track  <= 1'b0;
      drdy_n <= 1'b1;
    end else begin
      if (data_load) begin
        track <= 1'b1;
        cnt   <= '0;
      end else if (reg_load) begin
        track <= 1'b0;
      end else if (shift && track) begin
        if (last_bit) track <= 1'b0;
        else          cnt   <= cnt + 1'b1;
      end

      if (conv_valid)     drdy_n <= 1'b0;
      else if (conv_soon) drdy_n <= 1'b1;
      else if (last_bit)  drdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DW   = 24,
  parameter int NREG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_valid,
  input  logic [DW-1:0]    conv_data,
  input  logic             conv_soon,
  input  logic [NREG*8-1:0] reg_bank,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             drdy_n
);
  localparam int AW     = $clog2(NREG);
  localparam int NBYTES = DW / 8;

  logic [DW-1:0] shreg, hold;
  logic [2:0]    bitcnt;
  logic [7:0]    cmd_sr;
  logic          byte_full;
  phase_e        phase;
  logic [7:0]    left;
  logic [AW-1:0] addr, next_addr;
  logic [7:0]    regs [NREG];

  logic rise, fall;
  logic cont, stop_pend, auto_load;
  logic start_cmd, stop_cmd, data_load, reg_load, shift_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign regs[g] = reg_bank[g*8 +: 8];
  end

  adc_rd_edge u_edge (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .rise(rise), .fall(fall)
  );

  adc_rd_mode u_mode (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .cont(cont), .stop_pend(stop_pend), .auto_load(auto_load)
  );

  adc_rd_drdy #(.DW(DW)) u_drdy (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_soon(conv_soon),
    .data_load(data_load | auto_load), .reg_load(reg_load), .shift(shift_en),
    .drdy_n(drdy_n)
  );

  // Byte-boundary decode: what the falling edge does to the shift register
  always_comb begin
    start_cmd = 1'b0;
    stop_cmd  = 1'b0;
    data_load = 1'b0;
    reg_load  = 1'b0;
    shift_en  = 1'b0;
    next_addr = addr;
    if (!auto_load && fall) begin
      if (!byte_full) begin
        shift_en = 1'b1;
      end else begin
        unique case (phase)
          PH_CMD: begin
            if (cmd_sr == OP_RDATA) begin
              data_load = 1'b1;
            end else begin
              shift_en  = 1'b1;
              start_cmd = (cmd_sr == OP_START);
              stop_cmd  = (cmd_sr == OP_STOP);
            end
          end
          PH_CNT: reg_load = 1'b1;
          PH_REG: begin
            if (left == 8'd0) begin
              shift_en = 1'b1;
            end else begin
              reg_load  = 1'b1;
              next_addr = addr + 1'b1;
            end
          end
          PH_DATA: shift_en = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      hold      <= '0;
      bitcnt    <= '0;
      cmd_sr    <= '0;
      byte_full <= 1'b0;
      phase     <= PH_CMD;
      left      <= '0;
      addr      <= '0;
    end else begin
      if (conv_valid) hold <= conv_data;

      if (auto_load) begin
        shreg     <= conv_data;
        bitcnt    <= '0;
        byte_full <= 1'b0;
        phase     <= PH_CMD;
      end else if (cs_n) begin
        bitcnt    <= '0;
        byte_full <= 1'b0;
        phase     <= PH_CMD;
      end else if (rise) begin
        cmd_sr    <= {cmd_sr[6:0], din};
        bitcnt    <= bitcnt + 1'b1;
        byte_full <= (bitcnt == 3'd7);
      end else if (fall) begin
        byte_full <= 1'b0;
        if (shift_en)  shreg <= {shreg[DW-2:0], 1'b0};
        if (data_load) shreg <= hold;
        if (reg_load) begin
          shreg <= {regs[next_addr], {(DW-8){1'b0}}};
          addr  <= next_addr;
        end
        if (byte_full) begin
          unique case (phase)
            PH_CMD: begin
              if (cmd_sr == OP_RDATA) begin
                phase <= PH_DATA;
                left  <= 8'(NBYTES - 1);
              end else if (cmd_sr[7:4] == OP_RREG) begin
                phase <= PH_CNT;
                addr  <= cmd_sr[AW-1:0];
              end
            end
            PH_CNT: begin
              phase <= PH_REG;
              left  <= cmd_sr;
            end
            PH_REG, PH_DATA: begin
              if (left == 8'd0) phase <= PH_CMD;
              else              left  <= left - 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign dout = cs_n ? 1'b0 : shreg[DW-1];
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_valid,
  input logic [DW-1:0] conv_data,
  input logic          cs_n,
  input logic          drdy_n,
  input logic          cont,
  input logic          stop_pend,
  input logic          start_cmd,
  input logic          auto_load,
  input logic [DW-1:0] shreg
);
  // R2
  drdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> !drdy_n);

  // R10
  drdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drdy_n && !conv_valid) |=> drdy_n);

  // R5
  auto_load_chk: assert property (@(posedge clk) disable iff (rst)
    auto_load |=> (shreg == $past(conv_data)));

  // R6
  stop_take_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_pend && conv_valid) |=> !cont);

  // R7
  stopped_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!cont && cs_n && conv_valid) |=> $stable(shreg));

  // R8
  start_mode_chk: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> cont);
endmodule

bind adc_readout_ctrl adc_readout_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
  .cs_n(cs_n), .drdy_n(drdy_n), .cont(cont), .stop_pend(stop_pend),
  .start_cmd(start_cmd), .auto_load(auto_load), .shreg(shreg)
);

// File: tb/adc_readout_ctrl_tb.sv
`timescale 1ns/1ps
module adc_readout_ctrl_tb;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [23:0] conv_data = '0;
  logic        conv_soon = 1'b0;
  logic [31:0] reg_bank = 32'h44332211;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        dout, drdy_n;

  int    nchk = 0;
  int    nbad = 0;
  bit    started = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  adc_readout_ctrl u_dut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .conv_soon(conv_soon), .reg_bank(reg_bank), .cs_n(cs_n), .sclk(sclk),
    .din(din), .dout(dout), .drdy_n(drdy_n)
  );

  // ---------------- behavioural reference model ----------------
  bit          mq[$];
  int          m_bits = 0, m_ph = 0, m_left = 0, m_addr = 0, m_cnt = 0;
  bit          m_full = 0, m_cont = 1, m_pend = 0, m_drdy = 1, m_trk = 0, m_ps = 0;
  logic [7:0]  m_cmd = 0;
  logic [23:0] m_hold = 0;

  function automatic void mload(logic [23:0] v);
    mq.delete();
    for (int i = 23; i >= 0; i--) mq.push_back(v[i]);
  endfunction

  function automatic void mshift();
    void'(mq.pop_front());
    mq.push_back(1'b0);
  endfunction

  initial mload(24'h0);

  always @(posedge clk) begin
    bit rs, fl, al, ld, rl, sh, st, sp, hit;
    if (rst) begin
      mload(24'h0);
      m_bits = 0; m_ph = 0; m_left = 0; m_addr = 0; m_cnt = 0;
      m_full = 0; m_cont = 1; m_pend = 0; m_drdy = 1; m_trk = 0; m_ps = 0;
      m_cmd = 0; m_hold = 0;
    end else begin
      rs = sclk && !m_ps && !cs_n;
      fl = !sclk && m_ps && !cs_n;
      m_ps = sclk;
      al = conv_valid && m_cont;
      ld = al; rl = 0; sh = 0; st = 0; sp = 0; hit = 0;
      if (al) begin
        mload(conv_data); m_bits = 0; m_full = 0; m_ph = 0;
      end else if (cs_n) begin
        m_bits = 0; m_full = 0; m_ph = 0;
      end else if (rs) begin
        m_cmd = {m_cmd[6:0], din};
        m_bits++;
        m_full = (m_bits % 8 == 0);
      end else if (fl) begin
        if (!m_full) sh = 1;
        else begin
          m_full = 0;
          case (m_ph)
            0: if (m_cmd == 8'h12) begin
                 ld = 1; mload(m_hold); m_ph = 3; m_left = 2;
               end else begin
                 sh = 1; st = (m_cmd == 8'h14); sp = (m_cmd == 8'h16);
                 if (m_cmd[7:4] == 4'h2) begin m_ph = 1; m_addr = m_cmd[3:0] % 4; end
               end
            1: begin
                 rl = 1; mload({reg_bank[8*m_addr +: 8], 16'h0});
                 m_left = m_cmd; m_ph = 2;
               end
            2: if (m_left == 0) begin sh = 1; m_ph = 0; end
               else begin
                 m_addr = (m_addr + 1) % 4; rl = 1;
                 mload({reg_bank[8*m_addr +: 8], 16'h0}); m_left--;
               end
            default: begin sh = 1; if (m_left == 0) m_ph = 0; else m_left--; end
          endcase
        end
        if (sh) mshift();
      end
      if (conv_valid) m_hold = conv_data;
      if (ld) begin m_trk = 1; m_cnt = 0; end
      else if (rl) m_trk = 0;
      else if (sh && m_trk) begin
        if (m_cnt == 23) begin m_trk = 0; hit = 1; end else m_cnt++;
      end
      if (conv_valid) m_drdy = 0;
      else if (conv_soon) m_drdy = 1;
      else if (hit) m_drdy = 1;
      if (st) begin m_cont = 1; m_pend = 0; end
      else if (al && m_pend) begin m_cont = 0; m_pend = 0; end
      else if (sp && m_cont) m_pend = 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      logic exp_do;
      exp_do = cs_n ? 1'b0 : mq[0];
      nchk++;
      if (dout !== exp_do) begin
        nbad++;
        $display("FAIL %s model dout act=%b exp=%b t=%0t", cur_req, dout, exp_do, $time);
      end
      nchk++;
      if (drdy_n !== m_drdy) begin
        nbad++;
        $display("FAIL %s model drdy_n act=%b exp=%b t=%0t", cur_req, drdy_n, m_drdy, $time);
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      din = tx[i];
      wait_clk(H);
      rx[i] = dout;
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
    wait_clk(H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  task automatic conv(input logic [23:0] v);
    conv_data = v; conv_valid = 1'b1;
    wait_clk(1);
    conv_valid = 1'b0;
    wait_clk(2);
  endtask

  task automatic sel(input logic v);
    cs_n = v;
    wait_clk(H);
  endtask

  task automatic read3(input string tag, input logic [23:0] exp);
    logic [7:0] b0, b1, b2;
    xfer(8'h00, b0); xfer(8'h00, b1); xfer(8'h00, b2);
    check(tag, {8'h0, b0, b1, b2}, {8'h0, exp});
  endtask

  task automatic rdata3(input string tag, input logic [23:0] exp);
    logic [7:0] b0, b1, b2, bc;
    xfer(8'h12, bc);
    xfer(8'h00, b0); xfer(8'h00, b1); xfer(8'h00, b2);
    check(tag, {8'h0, b0, b1, b2}, {8'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    wait_clk(5);
    rst = 1'b0;
    started = 1;
    wait_clk(2);

    cur_req = "R1";
    check("R1 drdy_n after reset", {31'h0, drdy_n}, 32'h1);
    check("R1 dout with cs_n high", {31'h0, dout}, 32'h0);
    sel(1'b0);
    check("R1 shift register zero", {31'h0, dout}, 32'h0);
    sel(1'b1);

    cur_req = "R2";
    conv(24'hA5C3F1);
    check("R2 drdy_n low after result", {31'h0, drdy_n}, 32'h0);
    cur_req = "R3";
    sel(1'b0);
    read3("R3 bare continuous readout", 24'hA5C3F1);
    check("R10 drdy_n high after 24 bits", {31'h0, drdy_n}, 32'h1);
    sel(1'b1);

    cur_req = "R4";
    conv(24'h9ABCDE);
    sel(1'b0);
    xfer(8'h12, b);
    check("R4 command byte returns top of DOUT", {24'h0, b}, 32'h9A);
    read3("R4 data after read command", 24'h9ABCDE);
    sel(1'b1);

    cur_req = "R12";
    conv(24'h445566);
    sel(1'b0);
    xfer(8'h12, b);
    begin
      logic [7:0] x0, x1, x2;
      xfer(8'h16, x0); xfer(8'h00, x1); xfer(8'h00, x2);
      check("R12 stop byte in data phase not decoded, data intact", {8'h0, x0, x1, x2}, 32'h445566);
    end
    sel(1'b1);
    conv(24'h778899);
    sel(1'b0);
    read3("R12 still continuous after ignored byte", 24'h778899);
    sel(1'b1);

    cur_req = "R5";
    conv(24'h111111);
    sel(1'b0);
    xfer(8'h00, b);
    check("R5 first byte before overwrite", {24'h0, b}, 32'h11);
    conv(24'hCAFE01);
    read3("R5 new result overwrites transfer", 24'hCAFE01);
    sel(1'b1);

    cur_req = "R9";
    sel(1'b0);
    xfer(8'h22, b);
    xfer(8'h02, b);
    begin
      logic [7:0] r0, r1, r2;
      xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2);
      check("R9 register read with wrap", {8'h0, r0, r1, r2}, 32'h334411);
    end
    sel(1'b1);

    cur_req = "R6";
    sel(1'b0);
    xfer(8'h16, b);
    sel(1'b1);
    conv(24'h0A0B0C);
    sel(1'b0);
    read3("R6 one more automatic load", 24'h0A0B0C);
    sel(1'b1);
    conv(24'h0D0E0F);
    sel(1'b0);
    xfer(8'h00, b);
    check("R6 no automatic load after stop", {24'h0, b}, 32'h00);
    cur_req = "R7";
    xfer(8'h12, b);
    xfer(8'h00, b);
    check("R7 read data first byte", {24'h0, b}, 32'h0D);
    conv(24'h5A5A5A);
    check("R7 drdy_n falls in stopped mode", {31'h0, drdy_n}, 32'h0);
    begin
      logic [7:0] y1, y2;
      xfer(8'h00, y1); xfer(8'h00, y2);
      check("R7 read not disturbed by new result", {16'h0, y1, y2}, 32'h0E0F);
    end
    sel(1'b1);
    sel(1'b0);
    rdata3("R7 read data returns latest result", 24'h5A5A5A);
    sel(1'b1);

    cur_req = "R11";
    sel(1'b0);
    send_bits(8'h12, 4, b);
    sel(1'b1);
    conv(24'h606060);
    sel(1'b0);
    xfer(8'h00, b);
    check("R11 mode kept stopped across deselect", {24'h0, b}, 32'h00);
    rdata3("R11 decoder realigned after deselect", 24'h606060);
    sel(1'b1);

    cur_req = "R8";
    sel(1'b0);
    xfer(8'h14, b);
    sel(1'b1);
    conv(24'h31415F);
    sel(1'b0);
    read3("R8 continuous restored", 24'h31415F);
    sel(1'b1);

    cur_req = "R10";
    conv(24'h777777);
    check("R10 drdy_n low before early release", {31'h0, drdy_n}, 32'h0);
    conv_soon = 1'b1;
    wait_clk(1);
    conv_soon = 1'b0;
    wait_clk(2);
    check("R10 drdy_n high after conv_soon", {31'h0, drdy_n}, 32'h1);

    wait_clk(4);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule